// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block collects a set of external interrupt lines and turns each active line into an interrupt message. Every line has its own entry in a programmable redirection table. The entry holds a vector number, a delivery mode, a polarity, a trigger mode (edge or level), a mask bit and a 16-bit destination. The block sends the resulting message on a valid/ready output. When several lines want service at once, they are served in rotating order, one message per handshake.

Software reaches the table indirectly over a simple 32-bit register bus. It writes an index register to select a word, then reads or writes that word through a data window. Index 0x01 selects a read-only version word that reports the number of table entries. A separate end-of-interrupt register completes level-triggered interrupts by vector. One such write re-arms every level entry that carries the written vector.

Edge-triggered entries latch an active edge only while they are unmasked. An edge that arrives while the entry is masked is lost. Level-triggered entries hold a remote-busy flag from the time their message is issued until a matching end-of-interrupt arrives.

Top module: `irq_redir_ctrl`

## Requirements
- R1: Reading the window with index 0x01 returns the VERSION parameter in bits 7:0, NUM_PINS-1 in bits 23:16, and zero in bits 15:8 and 31:24.
- R2: After reset, no message is valid. Every entry's low word (index 0x10+2n) reads 0x0001_0000, which means masked with all other fields zero. Every high word (index 0x11+2n) reads 0.
- R3: The low word layout is: vector 7:0, delivery mode 10:8, polarity 13, remote-busy 14, trigger 15 and mask 16. All other bits read 0. Remote-busy ignores writes. The high word keeps the destination in bits 31:16 and reads 0 in bits 15:0. A window write to an index outside the table changes nothing, and a window read of such an index returns 0.
- R4: A message carries the vector, delivery mode and destination of its entry. The delivery mode codes are 0 fixed, 1 lowest-priority, 2 PMI and 5 INIT. While msg_ready is low, msg_valid and the message fields hold.
- R5: An unmasked edge entry sends exactly one message per active edge. Holding the line active sends nothing more.
- R6: An edge on a masked edge entry is discarded. A later unmask produces no message.
- R7: An unmasked level entry whose line is active sends one message and sets remote-busy. It sends nothing more until an end-of-interrupt clears remote-busy, even if the line stays active.
- R8: Writing the vector to the end-of-interrupt register (offset 0x40) clears remote-busy on every level entry with that vector. Each cleared entry whose line is still active resends. A write with a different vector has no effect.
- R9: A masked level entry sends nothing. Unmasking it while its line is active sends a message.
- R10: Pending entries are granted in rotating order. The search starts at the entry after the last one granted and wraps from NUM_PINS-1 to 0.
- R11: Polarity 1 makes the line active low. For an edge entry, a falling line is then the active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_PINS | External interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata one cycle later |
| reg_addr | input | 8 | Register offset: 0x00 index, 0x10 data window, 0x40 end-of-interrupt |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| msg_valid | output | 1 | Interrupt message valid |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_dest | output | 16 | Message destination (processor id high byte, extended id low byte) |

## Verification
The assertions run on every cycle and check five things:
- a message holds steady while it is stalled;
- no message is valid right after reset;
- an edge is latched only while the entry is unmasked;
- remote-busy is set only by the issue of that entry's own message;
- remote-busy stays set until a matching end-of-interrupt arrives.

Only the bench scenarios show the end-to-end ordering:
- that a dropped edge stays dropped after unmask;
- that one end-of-interrupt re-arms two entries sharing a vector;
- that a line still held after an end-of-interrupt is resent;
- that the arbiter wraps around rather than favouring low indices;
- that the register layout reads back as specified.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  // register bus offsets
  localparam logic [7:0] ADDR_IDX = 8'h00;
  localparam logic [7:0] ADDR_WIN = 8'h10;
  localparam logic [7:0] ADDR_EOI = 8'h40;
  // indirect index space
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam int         TBL_BASE = 16;
  // delivery mode codes
  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWPRI = 3'd1,
    DM_PMI    = 3'd2,
    DM_INIT   = 3'd5
  } dmode_e;
endpackage

// File: rtl/irq_pin_slot.sv
module irq_pin_slot (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  input  logic act_low,
  input  logic level,
  input  logic mask,
  input  logic issue,
  input  logic eoi_hit,
  output logic req,
  output logic rirr
);
  logic pin_q, act_prev, edge_pend;
  logic act;

  assign act = pin_q ^ act_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q     <= 1'b0;
      act_prev  <= 1'b0;
      edge_pend <= 1'b0;
      rirr      <= 1'b0;
    end else begin
      pin_q    <= pin_raw;
      act_prev <= act;
      if (level || mask || issue) edge_pend <= 1'b0;
      else if (act && !act_prev)  edge_pend <= 1'b1;
      if (!level)       rirr <= 1'b0;
      else if (issue)   rirr <= 1'b1;
      else if (eoi_hit) rirr <= 1'b0;
    end
  end

  assign req = !mask && (level ? (act && !rirr) : edge_pend);

  // R6
  edge_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(edge_pend) |-> $past(!mask))
    else $error("edge latched while masked");

  // R7
  busy_by_issue_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rirr) |-> $past(issue))
    else $error("remote-busy set without issue");

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rirr && level && !eoi_hit |=> rirr || !level)
    else $error("remote-busy cleared without EOI");
endmodule

// File: rtl/irq_rr_arb.sv
module irq_rr_arb #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  logic [IW-1:0] ptr;

  always_comb begin
    any     = 1'b0;
    gnt_idx = '0;
    for (int k = 1; k <= N; k++) begin
      if (!any && req[(int'(ptr) + k) % N]) begin
        any     = 1'b1;
        gnt_idx = IW'((int'(ptr) + k) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr <= IW'(N - 1);
    else if (take) ptr <= gnt_idx;
  end
endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int         NUM_PINS = 8,
  parameter logic [7:0] VERSION  = 8'h14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_in,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [7:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [2:0]          msg_dmode,
  output logic [15:0]         msg_dest
);
  localparam int IW = $clog2(NUM_PINS);

  logic [7:0]          idx_q;
  logic [7:0]          e_vec  [NUM_PINS];
  logic [2:0]          e_dm   [NUM_PINS];
  logic [15:0]         e_dest [NUM_PINS];
  logic [NUM_PINS-1:0] e_pol, e_trig, e_mask;
  logic [NUM_PINS-1:0] req_v, rirr_v;
  logic [IW-1:0]       gnt_idx;
  logic                req_any, load;

  // indirect index decode
  logic          idx_in_tbl, hi_word;
  logic [7:0]    tbl_off;
  logic [IW-1:0] ent;
  logic          win_wr, eoi_wr;

  assign idx_in_tbl = (int'(idx_q) >= TBL_BASE) && (int'(idx_q) < TBL_BASE + 2*NUM_PINS);
  assign tbl_off    = idx_q - 8'(TBL_BASE);
  assign ent        = tbl_off[IW:1];
  assign hi_word    = tbl_off[0];
  assign win_wr     = reg_wr && (reg_addr == ADDR_WIN);
  assign eoi_wr     = reg_wr && (reg_addr == ADDR_EOI);

  always_ff @(posedge clk) begin
    if (rst)                                      idx_q <= '0;
    else if (reg_wr && (reg_addr == ADDR_IDX))    idx_q <= reg_wdata[7:0];
  end

  // table entries
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        e_vec[i]  <= '0;
        e_dm[i]   <= '0;
        e_dest[i] <= '0;
      end
      e_pol  <= '0;
      e_trig <= '0;
      e_mask <= '1;
    end else if (win_wr && idx_in_tbl) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (ent == IW'(i)) begin
          if (hi_word) begin
            e_dest[i] <= reg_wdata[31:16];
          end else begin
            e_vec[i]  <= reg_wdata[7:0];
            e_dm[i]   <= reg_wdata[10:8];
            e_pol[i]  <= reg_wdata[13];
            e_trig[i] <= reg_wdata[15];
            e_mask[i] <= reg_wdata[16];
          end
        end
      end
    end
  end

  // register read path
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      if (reg_addr == ADDR_IDX) begin
        reg_rdata <= {24'd0, idx_q};
      end else if (reg_addr == ADDR_WIN) begin
        if (idx_q == IDX_VER)
          reg_rdata <= {8'd0, 8'(NUM_PINS - 1), 8'd0, VERSION};
        else if (idx_in_tbl && hi_word)
          reg_rdata <= {e_dest[ent], 16'd0};
        else if (idx_in_tbl)
          reg_rdata <= {15'd0, e_mask[ent], e_trig[ent], rirr_v[ent], e_pol[ent],
                        2'b00, e_dm[ent], e_vec[ent]};
      end
    end
  end

  // per-pin capture and remote-busy state
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_slot
    irq_pin_slot u_slot (
      .clk     (clk),
      .rst     (rst),
      .pin_raw (irq_in[g]),
      .act_low (e_pol[g]),
      .level   (e_trig[g]),
      .mask    (e_mask[g]),
      .issue   (load && (gnt_idx == IW'(g))),
      .eoi_hit (eoi_wr && e_trig[g] && (e_vec[g] == reg_wdata[7:0])),
      .req     (req_v[g]),
      .rirr    (rirr_v[g])
    );
  end

  irq_rr_arb #(.N(NUM_PINS)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (req_v),
    .take    (load),
    .gnt_idx (gnt_idx),
    .any     (req_any)
  );

  assign load = !msg_valid && req_any;

  // output message register
  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid  <= 1'b0;
      msg_vector <= '0;
      msg_dmode  <= '0;
      msg_dest   <= '0;
    end else if (load) begin
      msg_valid  <= 1'b1;
      msg_vector <= e_vec[gnt_idx];
      msg_dmode  <= e_dm[gnt_idx];
      msg_dest   <= e_dest[gnt_idx];
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R4
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector)
                                && $stable(msg_dmode) && $stable(msg_dest))
    else $error("message changed while stalled");

  // R2
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !msg_valid)
    else $error("message valid right after reset");
endmodule

// File: tb/sim_irq_redir_ctrl.sv
`timescale 1ns/1ps
module sim_irq_redir_ctrl;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] irq_in = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          msg_valid, msg_ready = 1'b0;
  logic [7:0]    msg_vector;
  logic [2:0]    msg_dmode;
  logic [15:0]   msg_dest;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_redir_ctrl #(.NUM_PINS(NP), .VERSION(8'h14)) u0 (.*);

  // table rows: {index, write data, expected read-back}
  localparam logic [71:0] TBL [4] = '{
    {8'h1C, 32'hFFFF_FFFF, 32'h0001_A7FF},
    {8'h1D, 32'hFFFF_FFFF, 32'hFFFF_0000},
    {8'h1A, 32'h0000_4123, 32'h0000_0123},
    {8'h30, 32'hDEAD_BEEF, 32'h0000_0000}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic win_wr(input logic [7:0] i, input logic [31:0] d);
    wr(8'h00, {24'd0, i}); wr(8'h10, d);
  endtask

  task automatic win_rd(input logic [7:0] i, output logic [31:0] d);
    wr(8'h00, {24'd0, i}); rd(8'h10, d);
  endtask

  // wait for a message, compare, then accept it
  task automatic take_msg(input string tag, input logic [7:0] vec,
                          input logic [2:0] dm, input logic [15:0] dst, input bit full);
    bit seen = 1'b0;
    for (int c = 0; c < 16 && !seen; c++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    if (!seen) begin
      chk(1'b0, {tag, " no message"}, 32'd0, {24'd0, vec});
    end else begin
      chk(msg_vector == vec, {tag, " vector"}, {24'd0, msg_vector}, {24'd0, vec});
      if (full) begin
        chk(msg_dmode == dm, {tag, " dmode"}, {29'd0, msg_dmode}, {29'd0, dm});
        chk(msg_dest == dst, {tag, " dest"}, {16'd0, msg_dest}, {16'd0, dst});
      end
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
    end
  endtask

  task automatic no_msg(input string tag, input int n);
    bit seen = 1'b0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    chk(!seen, {tag, " unexpected message"}, {31'd0, seen}, 32'd0);
    if (seen) begin
      msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    chk(!msg_valid, "R2 msg_valid after reset", {31'd0, msg_valid}, 32'd0);
    win_rd(8'h10, d); chk(d == 32'h0001_0000, "R2 entry0 low", d, 32'h0001_0000);
    win_rd(8'h1F, d); chk(d == 32'h0, "R2 entry7 high", d, 32'h0);
    win_rd(8'h13, d); chk(d == 32'h0, "R2 entry1 high", d, 32'h0);

    // R1 version word
    win_rd(8'h01, d); chk(d == 32'h0007_0014, "R1 version", d, 32'h0007_0014);

    // R3 layout, read-only busy bit, out-of-range index
    for (int i = 0; i < 4; i++) begin
      win_wr(TBL[i][71:64], TBL[i][63:32]);
      win_rd(TBL[i][71:64], d);
      chk(d == TBL[i][31:0], "R3 table row", d, TBL[i][31:0]);
    end
    win_rd(8'h10, d); chk(d == 32'h0001_0000, "R3 out-of-range write left entry0", d, 32'h0001_0000);
    win_wr(8'h1C, 32'h0001_0000);

    // R4 R5 edge entry 0: PMI, dest 0x1234
    win_wr(8'h11, 32'h1234_0000);
    win_wr(8'h10, 32'h0000_0230);
    irq_in[0] = 1'b1;
    take_msg("R4 R5 edge entry0", 8'h30, 3'd2, 16'h1234, 1'b1);
    no_msg("R5 held edge line", 10);

    // R6 edge while masked is dropped
    win_wr(8'h10, 32'h0001_0230);
    irq_in[0] = 1'b0; repeat (3) @(negedge clk);
    irq_in[0] = 1'b1; repeat (4) @(negedge clk);
    win_wr(8'h10, 32'h0000_0230);
    no_msg("R6 unmask after dropped edge", 10);

    // R11 active-low edge, INIT mode
    win_wr(8'h12, 32'h0001_2531);
    irq_in[1] = 1'b1; repeat (3) @(negedge clk);
    win_wr(8'h12, 32'h0000_2531);
    no_msg("R11 idle high line", 6);
    irq_in[1] = 1'b0;
    take_msg("R11 R4 falling edge INIT", 8'h31, 3'd5, 16'h0000, 1'b1);

    // R9 masked level entry, then unmask
    win_wr(8'h14, 32'h0001_8042);
    irq_in[2] = 1'b1;
    no_msg("R9 masked level", 8);
    win_wr(8'h14, 32'h0000_8042);
    take_msg("R9 unmask active level", 8'h42, 3'd0, 16'h0, 1'b0);

    // R7 remote-busy blocks repeats
    no_msg("R7 held level line", 10);
    win_rd(8'h14, d); chk(d == 32'h0000_C042, "R7 busy bit set", d, 32'h0000_C042);

    // R8 wrong vector EOI, then matching EOI with line still high
    wr(8'h40, 32'h41);
    no_msg("R8 mismatched EOI", 8);
    wr(8'h40, 32'h42);
    take_msg("R8 resend after EOI", 8'h42, 3'd0, 16'h0, 1'b0);
    irq_in[2] = 1'b0;
    wr(8'h40, 32'h42);
    no_msg("R8 EOI with line idle", 8);
    win_rd(8'h14, d); chk(d == 32'h0000_8042, "R8 busy bit cleared", d, 32'h0000_8042);

    // R8 shared vector: one EOI re-arms two entries
    win_wr(8'h16, 32'h0000_8050);
    win_wr(8'h18, 32'h0000_8050);
    irq_in[4:3] = 2'b11;
    take_msg("R8 shared first", 8'h50, 3'd0, 16'h0, 1'b0);
    take_msg("R8 shared second", 8'h50, 3'd0, 16'h0, 1'b0);
    no_msg("R8 shared both busy", 8);
    wr(8'h40, 32'h50);
    take_msg("R8 shared rearm first", 8'h50, 3'd0, 16'h0, 1'b0);
    take_msg("R8 shared rearm second", 8'h50, 3'd0, 16'h0, 1'b0);
    irq_in[4:3] = 2'b00;
    wr(8'h40, 32'h50);
    no_msg("R8 shared idle", 6);

    // R10 rotating order among edge entries 5,6,7
    win_wr(8'h1A, 32'h0000_0060);
    win_wr(8'h1C, 32'h0000_0061);
    win_wr(8'h1E, 32'h0000_0062);
    irq_in[7:5] = 3'b111; repeat (3) @(negedge clk); irq_in[7:5] = 3'b000;
    take_msg("R10 first of three", 8'h60, 3'd0, 16'h0, 1'b0);
    take_msg("R10 second of three", 8'h61, 3'd0, 16'h0, 1'b0);
    take_msg("R10 third of three", 8'h62, 3'd0, 16'h0, 1'b0);
    irq_in[6] = 1'b1; repeat (3) @(negedge clk); irq_in[6] = 1'b0;
    take_msg("R10 lone entry6", 8'h61, 3'd0, 16'h0, 1'b0);
    irq_in[7] = 1'b1; irq_in[5] = 1'b1; repeat (3) @(negedge clk);
    irq_in[7] = 1'b0; irq_in[5] = 1'b0;
    take_msg("R10 after 6 grant 7 first", 8'h62, 3'd0, 16'h0, 1'b0);
    take_msg("R10 wrap to 5", 8'h60, 3'd0, 16'h0, 1'b0);
    no_msg("R10 drained", 6);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule